// File: doc/BRIEF.md
# Double-Edge Strobe Word Receiver with Flow Pause

This block is the receiving end of a source-synchronous data-out burst. A sender places a 16-bit word on a parallel bus and then toggles a strobe. Each toggle, rising or falling, delivers one word. The receiver brings the strobe and the bus into its own clock domain and detects every toggle there. It stores each word in a local queue and offers the words in arrival order on a valid/ready output stream.

Two control lines go back to the sender. The first is an active-high request line, which stays high for the whole burst. The second is an active-low ready line, which lets the sender keep strobing. When the queue runs low on space, the receiver negates ready to pause the sender, and it asserts ready again once space returns.

Words can still arrive after ready is negated, because of cable delay and the sender's reaction time. The receiver therefore sets aside one or two spare words. The number depends on how long ago the last strobe toggle was when ready was negated. When the local logic asks for the burst to end, the receiver negates ready first. It then waits a fixed number of cycles before it drops the request line.

Top module: `dstrobe_rx`

## Requirements
- R1: Every toggle of `strb_i`, in either direction, captures the word on `dd_i`. Captured words appear on `out_data_o` in the order they arrived, while `out_valid_o` is high. A word leaves the queue on each cycle in which `out_valid_o` and `out_ready_i` are both high.
- R2: After a burst starts, `rdy_n_o` stays low (ready asserted) until at least one word of that burst has been captured. This holds even when the queue is already short of space.
- R3: During a burst that has received at least one word, `rdy_n_o` goes high (paused) when the free queue space falls to PAUSE_FREE entries (3 by default) or fewer. It returns low once the free space rises above PAUSE_FREE again.
- R4: Suppose ready is negated fewer than WINDOW_CYC clock cycles after the most recent captured toggle. Then exactly one more word is accepted. Any further word is dropped and sets `overflow_o`.
- R5: Suppose ready is negated WINDOW_CYC or more cycles after the most recent captured toggle. Then exactly two more words are accepted. Any further word is dropped and sets `overflow_o`.
- R6: A gap in strobe toggles, of any length, leaves `req_o` high and `rdy_n_o` low during an active burst.
- R7: A one-cycle pulse on `start_i` while idle raises `req_o` and drives `rdy_n_o` low from the next clock edge on.
- R8: `finish_i` during a burst first raises `rdy_n_o`. `req_o` then falls exactly RP_CYC clock cycles later.
- R9: After reset, `req_o` is 0, `rdy_n_o` is 1, `out_valid_o` is 0 and `overflow_o` is 0. Once `overflow_o` is set, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse: begin a burst (raise request) |
| finish_i | input | 1 | Pulse: end the current burst |
| strb_i | input | 1 | Sender strobe; each toggle delivers a word |
| dd_i | input | 16 | Sender data bus |
| req_o | output | 1 | Burst request, active high |
| rdy_n_o | output | 1 | Ready to the sender, active low |
| out_valid_o | output | 1 | Output stream word valid |
| out_data_o | output | 16 | Output stream word |
| out_ready_i | input | 1 | Output stream consumer ready |
| overflow_o | output | 1 | Sticky: a word arrived beyond the allowance |

## Verification
The bench builds the receiver with an 8-entry queue, a 4-cycle window and a 5-cycle ready-to-request delay. With these values, five stored words are enough to reach the pause threshold, and the one-spare and two-spare cases can each be pushed to overflow within a few toggles. A short window lets an idle gap of twenty cycles select the two-word allowance. A word spacing of ten cycles, with the pause decision made one cycle after a capture, selects the one-word allowance. The small delay lets the bench count the exact cycles between ready rising and request falling.

// File: rtl/dstrobe_pkg.sv
package dstrobe_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_PAUSED,
        ST_ENDING
    } link_state_e;

    typedef struct packed {
        logic              hit;
        logic [WORD_W-1:0] word;
    } capture_t;

    // Spare words owed to the sender once ready is negated.
    function automatic logic [1:0] spare_words(input int unsigned since_edge,
                                               input int unsigned window);
        return (since_edge < window) ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/dstrobe_sync.sv
module dstrobe_sync #(
    parameter int W      = 17,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d_i;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dstrobe_edge.sv
module dstrobe_edge
    import dstrobe_pkg::*;
#(
    parameter int WINDOW = 6,
    parameter int CNT_W  = $clog2(WINDOW + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strb_s,
    input  logic [WORD_W-1:0] word_s,
    output capture_t          cap_o,
    output logic [CNT_W-1:0]  since_o
);
    logic             prev_q;
    logic [CNT_W-1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            since_q <= CNT_W'(WINDOW);
        end else begin
            prev_q <= strb_s;
            if (strb_s != prev_q)
                since_q <= '0;
            else if (since_q != CNT_W'(WINDOW))
                since_q <= since_q + 1'b1;
        end
    end

    assign cap_o.hit  = strb_s ^ prev_q;
    assign cap_o.word = word_s;
    assign since_o    = since_q;

    // R1: a capture restarts the edge-age counter
    p_since_restart_r1: assert property (@(posedge clk) disable iff (rst)
        cap_o.hit |=> since_o == '0);
endmodule

// File: rtl/dstrobe_fifo.sv
module dstrobe_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic [W-1:0]  data_i,
    input  logic          pop_ready_i,
    output logic          valid_o,
    output logic [W-1:0]  data_o,
    output logic [CW-1:0] free_o,
    output logic          full_o
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign valid_o = cnt_q != '0;
    assign full_o  = cnt_q == CW'(DEPTH);
    assign free_o  = CW'(DEPTH) - cnt_q;
    assign data_o  = mem[rd_q];
    assign pop     = valid_o && pop_ready_i;

    always_ff @(posedge clk) begin
        if (push_i) mem[wr_q] <= data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) wr_q <= bump(wr_q);
            if (pop)    rd_q <= bump(rd_q);
            case ({push_i, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R4: the queue is never written while full
    p_no_push_full_r4: assert property (@(posedge clk) disable iff (rst)
        push_i |-> !full_o);
    // R1: a held word stays put while not taken
    p_hold_word_r1: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !pop_ready_i) |=> valid_o && $stable(data_o));
endmodule

// File: rtl/dstrobe_ctrl.sv
module dstrobe_ctrl
    import dstrobe_pkg::*;
#(
    parameter int FREE_W     = 5,
    parameter int CNT_W      = 3,
    parameter int PAUSE_FREE = 3,
    parameter int WINDOW     = 6,
    parameter int RP_CYC     = 10,
    parameter int RPW        = $clog2(RP_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              finish_i,
    input  logic              cap_hit_i,
    input  logic [CNT_W-1:0]  since_i,
    input  logic [FREE_W-1:0] free_i,
    input  logic              full_i,
    output logic              push_o,
    output logic              req_o,
    output logic              rdy_n_o,
    output logic              overflow_o
);
    link_state_e    state_q, state_d;
    logic           got_word_q;
    logic [1:0]     allow_q, extra_q;
    logic [RPW-1:0] wait_q;
    logic           ovf_q;
    logic           in_flow, low_space, accept;

    assign in_flow   = state_q == ST_ACTIVE;
    assign low_space = free_i <= FREE_W'(PAUSE_FREE);
    assign accept    = cap_hit_i && !full_i && (in_flow || extra_q < allow_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_ACTIVE;
            ST_ACTIVE: begin
                if (finish_i)                      state_d = ST_ENDING;
                else if (got_word_q && low_space)  state_d = ST_PAUSED;
            end
            ST_PAUSED: begin
                if (finish_i)        state_d = ST_ENDING;
                else if (!low_space) state_d = ST_ACTIVE;
            end
            ST_ENDING: if (wait_q == RPW'(RP_CYC - 1)) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            got_word_q <= 1'b0;
            allow_q    <= 2'd0;
            extra_q    <= 2'd0;
            wait_q     <= '0;
            ovf_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cap_hit_i && !in_flow && extra_q != 2'd3)
                extra_q <= extra_q + 1'b1;
            if (state_q == ST_IDLE && start_i) begin
                extra_q    <= 2'd0;
                got_word_q <= 1'b0;
            end
            if (in_flow && state_d != ST_ACTIVE) begin
                allow_q <= spare_words(int'(since_i), WINDOW);
                extra_q <= 2'd0;
            end
            if (state_q == ST_PAUSED && state_d == ST_ACTIVE)
                extra_q <= 2'd0;
            if (in_flow && accept)
                got_word_q <= 1'b1;
            if (state_q == ST_ENDING) wait_q <= wait_q + 1'b1;
            else                      wait_q <= '0;
            if (cap_hit_i && !accept)
                ovf_q <= 1'b1;
        end
    end

    assign push_o     = accept;
    assign req_o      = state_q != ST_IDLE;
    assign rdy_n_o    = state_q != ST_ACTIVE;
    assign overflow_o = ovf_q;

    // R2: no pause before the first word of a burst
    p_no_early_pause_r2: assert property (@(posedge clk) disable iff (rst)
        (in_flow && !got_word_q && !finish_i) |=> state_q == ST_ACTIVE);
    // R8: request drops only after ready was already negated
    p_ready_before_req_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(req_o) |-> (rdy_n_o && $past(rdy_n_o)));
    // R6: silence on the strobe never ends an active burst
    p_keep_request_r6: assert property (@(posedge clk) disable iff (rst)
        (in_flow && !finish_i) |=> req_o);
    // R9: overflow is sticky
    p_sticky_ovf_r9: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> overflow_o);
    // R4: at most two spare words ever follow a negated ready
    p_spare_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (!in_flow && push_o) |-> extra_q < 2'd2);
endmodule

// File: rtl/dstrobe_rx.sv
module dstrobe_rx
    import dstrobe_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int WINDOW_CYC  = 6,
    parameter int RP_CYC      = 10,
    parameter int PAUSE_FREE  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              finish_i,
    input  logic              strb_i,
    input  logic [WORD_W-1:0] dd_i,
    output logic              req_o,
    output logic              rdy_n_o,
    output logic              out_valid_o,
    output logic [WORD_W-1:0] out_data_o,
    input  logic              out_ready_i,
    output logic              overflow_o
);
    localparam int FREE_W = $clog2(DEPTH + 1);
    localparam int CNT_W  = $clog2(WINDOW_CYC + 1);

    logic [WORD_W:0]   synced;
    capture_t          cap;
    logic [CNT_W-1:0]  since;
    logic [FREE_W-1:0] free;
    logic              full, push;

    dstrobe_sync #(.W(WORD_W + 1), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({strb_i, dd_i}),
        .q_o (synced)
    );

    dstrobe_edge #(.WINDOW(WINDOW_CYC), .CNT_W(CNT_W)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .strb_s  (synced[WORD_W]),
        .word_s  (synced[WORD_W-1:0]),
        .cap_o   (cap),
        .since_o (since)
    );

    dstrobe_fifo #(.DEPTH(DEPTH), .W(WORD_W), .CW(FREE_W)) u_fifo (
        .clk         (clk),
        .rst         (rst),
        .push_i      (push),
        .data_i      (cap.word),
        .pop_ready_i (out_ready_i),
        .valid_o     (out_valid_o),
        .data_o      (out_data_o),
        .free_o      (free),
        .full_o      (full)
    );

    dstrobe_ctrl #(
        .FREE_W     (FREE_W),
        .CNT_W      (CNT_W),
        .PAUSE_FREE (PAUSE_FREE),
        .WINDOW     (WINDOW_CYC),
        .RP_CYC     (RP_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .finish_i   (finish_i),
        .cap_hit_i  (cap.hit),
        .since_i    (since),
        .free_i     (free),
        .full_i     (full),
        .push_o     (push),
        .req_o      (req_o),
        .rdy_n_o    (rdy_n_o),
        .overflow_o (overflow_o)
    );
endmodule

// File: tb/sim_dstrobe_rx.sv
module sim_dstrobe_rx;
    localparam int DEPTH = 8;
    localparam int WIN   = 4;
    localparam int RP    = 5;

    logic        clk = 1'b0;
    logic        rst, start_i, finish_i, strb_i, out_ready_i;
    logic [15:0] dd_i;
    logic        req_o, rdy_n_o, out_valid_o, overflow_o;
    logic [15:0] out_data_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [15:0] got [32];
    int ngot;

    always #5 clk = ~clk;

    dstrobe_rx #(.DEPTH(DEPTH), .SYNC_STAGES(2), .WINDOW_CYC(WIN),
                 .RP_CYC(RP), .PAUSE_FREE(3)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .finish_i(finish_i),
        .strb_i(strb_i), .dd_i(dd_i), .req_o(req_o), .rdy_n_o(rdy_n_o),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o),
        .out_ready_i(out_ready_i), .overflow_o(overflow_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start_i = 1'b0; finish_i = 1'b0; strb_i = 1'b0;
        dd_i = '0; out_ready_i = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_word(input logic [15:0] w, input int gap);
        dd_i = w;
        repeat (2) @(negedge clk);
        strb_i = ~strb_i;
        repeat (gap) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain();
        ngot = 0;
        out_ready_i = 1'b1;
        for (int i = 0; i < 30; i++) begin
            if (out_valid_o && ngot < 32) begin
                got[ngot] = out_data_o;
                ngot++;
            end
            @(negedge clk);
        end
        out_ready_i = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check(req_o == 1'b0, "R9 reset req", int'(req_o), 0);
        check(rdy_n_o == 1'b1, "R9 reset rdy_n", int'(rdy_n_o), 1);
        check(out_valid_o == 1'b0, "R9 reset valid", int'(out_valid_o), 0);
        check(overflow_o == 1'b0, "R9 reset overflow", int'(overflow_o), 0);
    endtask

    task automatic t_basic_and_idle();
        do_reset();
        pulse_start();
        check(req_o == 1'b1, "R7 start req", int'(req_o), 1);
        check(rdy_n_o == 1'b0, "R7 start rdy_n", int'(rdy_n_o), 0);
        send_word(16'h1234, 8);
        send_word(16'hBEEF, 8);
        send_word(16'h0F0F, 8);
        drain();
        check(ngot == 3, "R1 word count", ngot, 3);
        check(got[0] == 16'h1234, "R1 word0 rising", int'(got[0]), 16'h1234);
        check(got[1] == 16'hBEEF, "R1 word1 falling", int'(got[1]), 16'hBEEF);
        check(got[2] == 16'h0F0F, "R1 word2 rising", int'(got[2]), 16'h0F0F);
        repeat (100) @(negedge clk);
        check(req_o == 1'b1, "R6 req after silence", int'(req_o), 1);
        check(rdy_n_o == 1'b0, "R6 rdy_n after silence", int'(rdy_n_o), 0);
    endtask

    task automatic t_pause_short();
        do_reset();
        pulse_start();
        for (int i = 0; i < 4; i++) send_word(16'hA000 + 16'(i), 8);
        check(rdy_n_o == 1'b0, "R3 no pause at free 4", int'(rdy_n_o), 0);
        send_word(16'hA004, 8);
        check(rdy_n_o == 1'b1, "R3 pause at free 3", int'(rdy_n_o), 1);
        send_word(16'hA005, 8);
        check(overflow_o == 1'b0, "R4 one spare stored", int'(overflow_o), 0);
        send_word(16'hA006, 8);
        check(overflow_o == 1'b1, "R4 second spare overflows", int'(overflow_o), 1);
        drain();
        check(ngot == 6, "R4 stored count", ngot, 6);
        check(got[5] == 16'hA005, "R4 spare word value", int'(got[5]), 16'hA005);
        check(rdy_n_o == 1'b0, "R3 resume after drain", int'(rdy_n_o), 0);
        check(overflow_o == 1'b1, "R9 overflow sticky", int'(overflow_o), 1);
    endtask

    task automatic t_end_long();
        int cnt;
        do_reset();
        pulse_start();
        send_word(16'hC000, 8);
        send_word(16'hC001, 20);
        finish_i = 1'b1;
        @(negedge clk);
        finish_i = 1'b0;
        check(rdy_n_o == 1'b1 && req_o == 1'b1, "R8 ready first", int'({rdy_n_o, req_o}), 3);
        cnt = 0;
        for (int i = 0; i < 40 && req_o; i++) begin
            if (rdy_n_o) cnt++;
            @(negedge clk);
        end
        check(cnt == RP, "R8 ready-to-request cycles", cnt, RP);
        send_word(16'hC002, 8);
        send_word(16'hC003, 8);
        check(overflow_o == 1'b0, "R5 two spares stored", int'(overflow_o), 0);
        send_word(16'hC004, 8);
        check(overflow_o == 1'b1, "R5 third spare overflows", int'(overflow_o), 1);
        drain();
        check(ngot == 4, "R5 stored count", ngot, 4);
        check(got[3] == 16'hC003, "R5 last spare value", int'(got[3]), 16'hC003);
    endtask

    task automatic t_early_pause();
        do_reset();
        pulse_start();
        for (int i = 0; i < 5; i++) send_word(16'hD000 + 16'(i), 8);
        finish_i = 1'b1;
        @(negedge clk);
        finish_i = 1'b0;
        repeat (RP + 4) @(negedge clk);
        check(req_o == 1'b0, "R8 burst ended", int'(req_o), 0);
        pulse_start();
        repeat (20) @(negedge clk);
        check(rdy_n_o == 1'b0, "R2 ready held before first word", int'(rdy_n_o), 0);
        send_word(16'hD100, 8);
        check(rdy_n_o == 1'b1, "R2 pause after first word", int'(rdy_n_o), 1);
    endtask

    initial begin
        t_reset_state();
        t_basic_and_idle();
        t_pause_short();
        t_end_long();
        t_early_pause();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule